// File: doc/BRIEF.md
# Shutdown Special-Cycle Controller

This block sits in the bus unit of a processor core. It tracks how deeply faults are nested. A fault with the double-fault vector marks a double fault. If any further fault arrives while that double fault is still being handled, the block treats it as a triple fault and enters shutdown.

On entry the block raises a halted status that stops ordinary bus traffic. It then waits for any bus cycle still in flight to finish. After that it issues exactly one special bus cycle whose byte-enable pattern marks it as a shutdown cycle. It holds that cycle on the bus until the system returns ready.

The core then stays halted until one of three wake-up sources is asserted: a non-maskable interrupt, a soft init or a system-management interrupt. A fourth source, the hard reset, acts as the block's synchronous reset. On a wake-up exit a one-cycle strobe reports which source caused the exit.

Top module: `shutdown_cycle_ctrl`

## Requirements
- R1: The fault level has three values: no fault, one fault, double fault. A fault strobe with vector 8 moves the level to double fault from no fault or from one fault. A fault with any other vector moves the level from no fault to one fault and otherwise leaves it unchanged. The handler-done input returns the level to no fault. When a fault strobe and handler-done arrive in the same cycle, the fault wins.
- R2: A fault strobe with any vector, arriving while the level is double fault, makes `halted_o` high from the next cycle.
- R3: While `bus_busy_i` is high after shutdown entry, `addr_strobe_o` stays low. `addr_strobe_o` goes high for exactly one cycle, in the cycle after the first clock edge at which the block is halted, not yet issued, and sees `bus_busy_i` low.
- R4: During the special cycle (the strobe cycle and any wait cycles that follow it), the outputs take these values: `byte_en_o` = 8'hFE, `addr_o` = 0, `mem_io_o` = 0, `data_code_o` = 0, `write_o` = 1. Outside the special cycle they take these values: `byte_en_o` = 8'hFF, `write_o` = 0, `addr_strobe_o` = 0.
- R5: `bus_ready_i` is accepted only from the cycle after the strobe. The special cycle stays on the bus until ready is seen, and it ends on the clock edge that samples ready. A ready seen during the strobe cycle itself is ignored.
- R6: Only one special cycle is issued per shutdown episode. No further strobe appears while the block stays halted.
- R7: `halted_o` stays high from shutdown entry until a wake-up exit or a hard reset. The wake-up inputs are honoured only after the special cycle has completed. Wake-up inputs asserted while the block is running, or before the cycle completes, have no effect.
- R8: A wake-up exit drops `halted_o` and pulses `wake_o` for one cycle. During that pulse `wake_src_o` shows the source: 2'd1 for non-maskable, 2'd2 for soft init, 2'd3 for system management. If several sources are asserted together, soft init wins over system management, which wins over non-maskable. `wake_src_o` is 2'd0 when no pulse is present.
- R9: `hard_rst_i` is synchronous and overrides everything else in any state. It returns the block to running with the level at no fault, idle bus outputs and no wake pulse.
- R10: A wake-up exit returns the fault level to no fault.
- R11: While halted, fault strobes and handler-done are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst_i | input | 1 | Synchronous hard reset, highest priority |
| fault_vld_i | input | 1 | One-cycle fault or interrupt event strobe |
| fault_vec_i | input | 8 | Vector number of the event |
| handler_done_i | input | 1 | The current fault handler has finished |
| bus_busy_i | input | 1 | An ordinary bus cycle is still in progress |
| bus_ready_i | input | 1 | System acknowledges the current bus cycle |
| wake_nonmask_i | input | 1 | Non-maskable interrupt wake-up request |
| wake_softinit_i | input | 1 | Soft init wake-up request |
| wake_sysmgmt_i | input | 1 | System-management interrupt wake-up request |
| addr_strobe_o | output | 1 | Address strobe, high in the first cycle of a bus cycle |
| byte_en_o | output | 8 | Active-low byte enables |
| addr_o | output | 29 | Address bits 31 down to 3 |
| mem_io_o | output | 1 | Memory (1) or I/O (0) cycle |
| data_code_o | output | 1 | Data (1) or code/special (0) cycle |
| write_o | output | 1 | Write (1) or read (0) cycle |
| halted_o | output | 1 | Shutdown in effect; ordinary traffic stopped |
| wake_o | output | 1 | One-cycle wake-up exit strobe |
| wake_src_o | output | 2 | Source of the wake-up exit |

## Verification
The hardest situation to bring about is a ready that arrives in the same cycle as the strobe. A ready that is too early must be ignored, and the cycle must then still wait for a later ready. To reach it, the bench holds the bus busy after entry, releases it, and asserts ready exactly in the strobe cycle. It then withholds ready for several cycles and watches the byte enables stay at the shutdown code. A second hard case is to show that fault events arriving while halted left no trace. The bench injects a double-fault vector while halted, wakes the block, and then shows that a single further fault does not cause shutdown again.

// File: rtl/shdn_pkg.sv
package shdn_pkg;

    localparam int SD_BE_W   = 8;
    localparam int SD_ADDR_W = 29;
    localparam int SD_VEC_W  = 8;
    localparam int SD_WAKE_N = 3;

    localparam logic [SD_VEC_W-1:0] SD_DF_VEC   = 8'd8;
    localparam logic [SD_BE_W-1:0]  SD_SHUT_BE  = 8'hFE;
    localparam logic [SD_BE_W-1:0]  SD_IDLE_BE  = '1;

    typedef enum logic [1:0] {
        NEST_NONE   = 2'd0,
        NEST_SINGLE = 2'd1,
        NEST_DOUBLE = 2'd2
    } nest_e;

    typedef enum logic [2:0] {
        SQ_RUN   = 3'd0,
        SQ_DRAIN = 3'd1,
        SQ_ISSUE = 3'd2,
        SQ_AWAIT = 3'd3,
        SQ_HALT  = 3'd4
    } seq_e;

    typedef enum logic [1:0] {
        WK_NONE     = 2'd0,
        WK_NONMASK  = 2'd1,
        WK_SOFTINIT = 2'd2,
        WK_SYSMGMT  = 2'd3
    } wake_e;

    typedef struct packed {
        logic                 strobe;
        logic [SD_BE_W-1:0]   be_n;
        logic [SD_ADDR_W-1:0] addr;
        logic                 mem_sel;
        logic                 data_sel;
        logic                 wr;
    } bus_cyc_t;

    function automatic bus_cyc_t idle_cycle();
        bus_cyc_t c;
        c.strobe   = 1'b0;
        c.be_n     = SD_IDLE_BE;
        c.addr     = '0;
        c.mem_sel  = 1'b0;
        c.data_sel = 1'b0;
        c.wr       = 1'b0;
        return c;
    endfunction

    function automatic bus_cyc_t shutdown_cycle(input logic first);
        bus_cyc_t c;
        c.strobe   = first;
        c.be_n     = SD_SHUT_BE;
        c.addr     = '0;
        c.mem_sel  = 1'b0;
        c.data_sel = 1'b0;
        c.wr       = 1'b1;
        return c;
    endfunction

    // request index 0 has the highest priority
    function automatic wake_e wake_src_of(input int idx);
        case (idx)
            0:       return WK_SOFTINIT;
            1:       return WK_SYSMGMT;
            2:       return WK_NONMASK;
            default: return WK_NONE;
        endcase
    endfunction

endpackage

// File: rtl/shdn_fault_nest.sv
module shdn_fault_nest
    import shdn_pkg::*;
#(
    parameter int                VEC_W  = SD_VEC_W,
    parameter logic [VEC_W-1:0]  DF_VEC = VEC_W'(SD_DF_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_vld_i,
    input  logic [VEC_W-1:0] fault_vec_i,
    input  logic             handler_done_i,
    input  logic             freeze_i,
    input  logic             clear_i,
    output logic             triple_o
);

    nest_e level_q;
    logic  is_df;

    assign is_df    = (fault_vec_i == DF_VEC);
    assign triple_o = fault_vld_i && !freeze_i && (level_q == NEST_DOUBLE);

    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            level_q <= NEST_NONE;
        end else if (!freeze_i) begin
            if (fault_vld_i) begin
                case (level_q)
                    NEST_NONE:   level_q <= is_df ? NEST_DOUBLE : NEST_SINGLE;
                    NEST_SINGLE: level_q <= is_df ? NEST_DOUBLE : NEST_SINGLE;
                    default:     level_q <= NEST_DOUBLE;
                endcase
            end else if (handler_done_i) begin
                level_q <= NEST_NONE;
            end
        end
    end

    AST_DF_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
        (fault_vld_i && is_df && !freeze_i && !clear_i && level_q == NEST_NONE)
        |=> (level_q == NEST_DOUBLE)); // R1

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (handler_done_i && !fault_vld_i && !freeze_i)
        |=> (level_q == NEST_NONE)); // R1

    AST_FROZEN_LEVEL: assert property (@(posedge clk) disable iff (rst)
        (freeze_i && !clear_i) |=> $stable(level_q)); // R11

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> (level_q == NEST_NONE)); // R10

endmodule

// File: rtl/shdn_wake_arb.sv
module shdn_wake_arb
    import shdn_pkg::*;
#(
    parameter int N = SD_WAKE_N
) (
    input  logic [N-1:0] req_i,
    input  logic         enable_i,
    output logic         any_o,
    output wake_e        src_o
);

    always_comb begin
        any_o = 1'b0;
        src_o = WK_NONE;
        for (int i = N - 1; i >= 0; i--) begin
            if (enable_i && req_i[i]) begin
                any_o = 1'b1;
                src_o = wake_src_of(i);
            end
        end
    end

endmodule

// File: rtl/shdn_cycle_seq.sv
module shdn_cycle_seq
    import shdn_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     triple_i,
    input  logic     bus_busy_i,
    input  logic     bus_ready_i,
    input  logic     wake_any_i,
    input  wake_e    wake_src_i,
    output bus_cyc_t cyc_o,
    output logic     halted_o,
    output logic     wake_en_o,
    output logic     exit_o,
    output logic     wake_o,
    output wake_e    wake_src_o
);

    seq_e  state_q, state_d;
    logic  issued_q;
    logic  wake_q;
    wake_e src_q;

    assign wake_en_o = (state_q == SQ_HALT);
    assign exit_o    = wake_en_o && wake_any_i;
    assign halted_o  = (state_q != SQ_RUN);

    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_RUN:   if (triple_i)     state_d = SQ_DRAIN;
            SQ_DRAIN: if (!bus_busy_i)  state_d = SQ_ISSUE;
            SQ_ISSUE:                   state_d = SQ_AWAIT;
            SQ_AWAIT: if (bus_ready_i)  state_d = SQ_HALT;
            SQ_HALT:  if (wake_any_i)   state_d = SQ_RUN;
            default:                    state_d = SQ_RUN;
        endcase
    end

    always_comb begin
        case (state_q)
            SQ_ISSUE: cyc_o = shutdown_cycle(1'b1);
            SQ_AWAIT: cyc_o = shutdown_cycle(1'b0);
            default:  cyc_o = idle_cycle();
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= SQ_RUN;
            issued_q <= 1'b0;
            wake_q   <= 1'b0;
            src_q    <= WK_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_RUN)
                issued_q <= 1'b0;
            else if (state_q == SQ_ISSUE)
                issued_q <= 1'b1;
            wake_q <= exit_o;
            src_q  <= exit_o ? wake_src_i : WK_NONE;
        end
    end

    assign wake_o     = wake_q;
    assign wake_src_o = src_q;

    AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_ISSUE) |-> !issued_q); // R6

    AST_NO_ISSUE_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (state_q == SQ_DRAIN && bus_busy_i) |=> (state_q == SQ_DRAIN)); // R3

    AST_EXIT_ONLY_FROM_HALT: assert property (@(posedge clk) disable iff (rst)
        (state_q != SQ_HALT && state_q != SQ_RUN) |=> (state_q != SQ_RUN)); // R7

endmodule

// File: rtl/shutdown_cycle_ctrl.sv
module shutdown_cycle_ctrl
    import shdn_pkg::*;
#(
    parameter int               VEC_W  = SD_VEC_W,
    parameter logic [VEC_W-1:0] DF_VEC = VEC_W'(SD_DF_VEC)
) (
    input  logic                 clk,
    input  logic                 hard_rst_i,
    input  logic                 fault_vld_i,
    input  logic [VEC_W-1:0]     fault_vec_i,
    input  logic                 handler_done_i,
    input  logic                 bus_busy_i,
    input  logic                 bus_ready_i,
    input  logic                 wake_nonmask_i,
    input  logic                 wake_softinit_i,
    input  logic                 wake_sysmgmt_i,
    output logic                 addr_strobe_o,
    output logic [SD_BE_W-1:0]   byte_en_o,
    output logic [SD_ADDR_W-1:0] addr_o,
    output logic                 mem_io_o,
    output logic                 data_code_o,
    output logic                 write_o,
    output logic                 halted_o,
    output logic                 wake_o,
    output logic [1:0]           wake_src_o
);

    logic                 triple;
    logic                 wake_en;
    logic                 wake_any;
    logic                 exit_now;
    logic [SD_WAKE_N-1:0] wake_req;
    wake_e                arb_src;
    wake_e                pulse_src;
    bus_cyc_t             cyc;

    // index 0 is the highest priority source
    assign wake_req = {wake_nonmask_i, wake_sysmgmt_i, wake_softinit_i};

    shdn_fault_nest #(
        .VEC_W  (VEC_W),
        .DF_VEC (DF_VEC)
    ) u_nest (
        .clk            (clk),
        .rst            (hard_rst_i),
        .fault_vld_i    (fault_vld_i),
        .fault_vec_i    (fault_vec_i),
        .handler_done_i (handler_done_i),
        .freeze_i       (halted_o),
        .clear_i        (exit_now),
        .triple_o       (triple)
    );

    shdn_wake_arb #(
        .N (SD_WAKE_N)
    ) u_arb (
        .req_i    (wake_req),
        .enable_i (wake_en),
        .any_o    (wake_any),
        .src_o    (arb_src)
    );

    shdn_cycle_seq u_seq (
        .clk         (clk),
        .rst         (hard_rst_i),
        .triple_i    (triple),
        .bus_busy_i  (bus_busy_i),
        .bus_ready_i (bus_ready_i),
        .wake_any_i  (wake_any),
        .wake_src_i  (arb_src),
        .cyc_o       (cyc),
        .halted_o    (halted_o),
        .wake_en_o   (wake_en),
        .exit_o      (exit_now),
        .wake_o      (wake_o),
        .wake_src_o  (pulse_src)
    );

    assign addr_strobe_o = cyc.strobe;
    assign byte_en_o     = cyc.be_n;
    assign addr_o        = cyc.addr;
    assign mem_io_o      = cyc.mem_sel;
    assign data_code_o   = cyc.data_sel;
    assign write_o       = cyc.wr;
    assign wake_src_o    = pulse_src;

    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (hard_rst_i)
        addr_strobe_o |=> !addr_strobe_o); // R3

    AST_STROBE_AFTER_IDLE_BUS: assert property (@(posedge clk) disable iff (hard_rst_i)
        addr_strobe_o |-> $past(!bus_busy_i)); // R3

    AST_SHUT_ENCODING: assert property (@(posedge clk) disable iff (hard_rst_i)
        addr_strobe_o |-> (byte_en_o == SD_SHUT_BE && write_o && !mem_io_o
                           && !data_code_o && addr_o == '0)); // R4

    AST_HOLD_TO_READY: assert property (@(posedge clk) disable iff (hard_rst_i)
        (byte_en_o == SD_SHUT_BE && !addr_strobe_o && !bus_ready_i)
        |=> (byte_en_o == SD_SHUT_BE)); // R5

    AST_ENTRY_ON_FAULT: assert property (@(posedge clk) disable iff (hard_rst_i)
        $rose(halted_o) |-> $past(fault_vld_i)); // R2

    AST_EXIT_ON_WAKE: assert property (@(posedge clk) disable iff (hard_rst_i)
        ($fell(halted_o) && !$past(hard_rst_i))
        |-> $past(wake_nonmask_i || wake_softinit_i || wake_sysmgmt_i)); // R7

    AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (hard_rst_i)
        wake_o |=> !wake_o); // R8

    AST_STROBE_HALTED: assert property (@(posedge clk) disable iff (hard_rst_i)
        addr_strobe_o |-> halted_o); // R6

endmodule

// File: tb/shutdown_cycle_ctrl_tb.sv
module shutdown_cycle_ctrl_tb;

    logic        clk = 1'b0;
    logic        hard_rst_i = 1'b1;
    logic        fault_vld_i = 1'b0;
    logic [7:0]  fault_vec_i = 8'd0;
    logic        handler_done_i = 1'b0;
    logic        bus_busy_i = 1'b0;
    logic        bus_ready_i = 1'b0;
    logic        wake_nonmask_i = 1'b0;
    logic        wake_softinit_i = 1'b0;
    logic        wake_sysmgmt_i = 1'b0;
    logic        addr_strobe_o;
    logic [7:0]  byte_en_o;
    logic [28:0] addr_o;
    logic        mem_io_o;
    logic        data_code_o;
    logic        write_o;
    logic        halted_o;
    logic        wake_o;
    logic [1:0]  wake_src_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    shutdown_cycle_ctrl u_dut (
        .clk             (clk),
        .hard_rst_i      (hard_rst_i),
        .fault_vld_i     (fault_vld_i),
        .fault_vec_i     (fault_vec_i),
        .handler_done_i  (handler_done_i),
        .bus_busy_i      (bus_busy_i),
        .bus_ready_i     (bus_ready_i),
        .wake_nonmask_i  (wake_nonmask_i),
        .wake_softinit_i (wake_softinit_i),
        .wake_sysmgmt_i  (wake_sysmgmt_i),
        .addr_strobe_o   (addr_strobe_o),
        .byte_en_o       (byte_en_o),
        .addr_o          (addr_o),
        .mem_io_o        (mem_io_o),
        .data_code_o     (data_code_o),
        .write_o         (write_o),
        .halted_o        (halted_o),
        .wake_o          (wake_o),
        .wake_src_o      (wake_src_o)
    );

    typedef struct packed {
        logic       rst;
        logic       fv;
        logic [7:0] vec;
        logic       done;
        logic       exp_halt;
    } row_t;

    // fault-nesting walk (R1, R2): a reset row applies one reset cycle first
    localparam row_t TAB [0:16] = '{
        '{1'b1, 1'b1, 8'd8,  1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd14, 1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd14, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd13, 1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd8,  1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
        '{1'b0, 1'b1, 8'd3,  1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd8,  1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd8,  1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd8,  1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
        '{1'b0, 1'b1, 8'd0,  1'b0, 1'b0},
        '{1'b0, 1'b0, 8'd0,  1'b1, 1'b0},
        '{1'b0, 1'b1, 8'd8,  1'b0, 1'b0},
        '{1'b0, 1'b1, 8'd6,  1'b0, 1'b1},
        '{1'b1, 1'b1, 8'd8,  1'b1, 1'b0},
        '{1'b0, 1'b1, 8'd5,  1'b0, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fault(input logic [7:0] v);
        fault_vld_i = 1'b1;
        fault_vec_i = v;
        step();
        fault_vld_i = 1'b0;
    endtask

    // bus idle: entry, drain, strobe, wait, ready, halted
    task automatic shut_to_halt();
        fault(8'd8);
        fault(8'd1);
        step();
        step();
        bus_ready_i = 1'b1;
        step();
        bus_ready_i = 1'b0;
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        step();
        step();
        chk("R9 halted after reset", 32'(halted_o), 32'd0);
        chk("R9 strobe after reset", 32'(addr_strobe_o), 32'd0);
        chk("R4 idle byte enables", 32'(byte_en_o), 32'hFF);
        chk("R9 wake pulse after reset", 32'(wake_o), 32'd0);
        chk("R4 idle write", 32'(write_o), 32'd0);
        hard_rst_i = 1'b0;

        for (int i = 0; i < 17; i++) begin
            if (TAB[i].rst) begin
                hard_rst_i = 1'b1;
                step();
                hard_rst_i = 1'b0;
            end
            fault_vld_i    = TAB[i].fv;
            fault_vec_i    = TAB[i].vec;
            handler_done_i = TAB[i].done;
            step();
            fault_vld_i    = 1'b0;
            handler_done_i = 1'b0;
            chk($sformatf("R1/R2 nesting row %0d", i), 32'(halted_o), 32'(TAB[i].exp_halt));
        end

        hard_rst_i = 1'b1;
        step();
        hard_rst_i = 1'b0;

        // R7: wake while running has no effect
        wake_nonmask_i = 1'b1;
        step();
        wake_nonmask_i = 1'b0;
        chk("R7 wake while running pulse", 32'(wake_o), 32'd0);
        chk("R7 wake while running halted", 32'(halted_o), 32'd0);

        // entry with bus busy
        bus_busy_i = 1'b1;
        fault(8'd8);
        fault(8'd2);
        chk("R2 entry halted", 32'(halted_o), 32'd1);
        wake_nonmask_i = 1'b1;
        step();
        wake_nonmask_i = 1'b0;
        chk("R7 early wake ignored halted", 32'(halted_o), 32'd1);
        chk("R7 early wake ignored pulse", 32'(wake_o), 32'd0);
        step();
        chk("R3 no strobe while busy", 32'(addr_strobe_o), 32'd0);
        step();
        chk("R3 still no strobe while busy", 32'(addr_strobe_o), 32'd0);

        bus_busy_i  = 1'b0;
        bus_ready_i = 1'b1;
        step();
        chk("R3 strobe after bus idle", 32'(addr_strobe_o), 32'd1);
        chk("R4 shutdown byte enables", 32'(byte_en_o), 32'hFE);
        chk("R4 address zero", 32'(addr_o), 32'd0);
        chk("R4 memory/io low", 32'(mem_io_o), 32'd0);
        chk("R4 data/code low", 32'(data_code_o), 32'd0);
        chk("R4 write high", 32'(write_o), 32'd1);
        step();
        bus_ready_i = 1'b0;
        chk("R3 strobe lasts one cycle", 32'(addr_strobe_o), 32'd0);
        chk("R5 ready in strobe cycle ignored", 32'(byte_en_o), 32'hFE);
        step();
        chk("R5 held without ready", 32'(byte_en_o), 32'hFE);
        step();
        chk("R5 still held without ready", 32'(write_o), 32'd1);
        bus_ready_i = 1'b1;
        step();
        bus_ready_i = 1'b0;
        chk("R5 cycle ends on ready", 32'(byte_en_o), 32'hFF);
        chk("R7 halted after cycle", 32'(halted_o), 32'd1);

        // R11: events while halted are ignored
        fault_vld_i    = 1'b1;
        fault_vec_i    = 8'd8;
        handler_done_i = 1'b1;
        step();
        fault_vld_i    = 1'b0;
        handler_done_i = 1'b0;
        chk("R11 fault while halted keeps halt", 32'(halted_o), 32'd1);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6 no second strobe", 32'(addr_strobe_o), 32'd0);
        end

        // R8: two sources, system management wins over non-maskable
        wake_nonmask_i = 1'b1;
        wake_sysmgmt_i = 1'b1;
        step();
        wake_nonmask_i = 1'b0;
        wake_sysmgmt_i = 1'b0;
        chk("R8 exit drops halted", 32'(halted_o), 32'd0);
        chk("R8 wake pulse", 32'(wake_o), 32'd1);
        chk("R8 source sysmgmt", 32'(wake_src_o), 32'd3);
        step();
        chk("R8 pulse one cycle", 32'(wake_o), 32'd0);
        chk("R8 source idle", 32'(wake_src_o), 32'd0);

        // R10: level cleared by wake (a fault ignored in halt left no trace)
        fault(8'd5);
        chk("R10 single fault after wake", 32'(halted_o), 32'd0);
        fault(8'd8);
        chk("R10 double fault after wake", 32'(halted_o), 32'd0);
        fault(8'd1);
        chk("R10 triple after wake", 32'(halted_o), 32'd1);
        step();
        step();
        chk("R9 in wait before reset", 32'(byte_en_o), 32'hFE);
        hard_rst_i = 1'b1;
        step();
        hard_rst_i = 1'b0;
        chk("R9 reset mid cycle halted", 32'(halted_o), 32'd0);
        chk("R9 reset mid cycle byte enables", 32'(byte_en_o), 32'hFF);
        chk("R9 reset mid cycle write", 32'(write_o), 32'd0);

        // R8: all three, soft init wins
        shut_to_halt();
        chk("R7 halted before wake", 32'(halted_o), 32'd1);
        wake_nonmask_i  = 1'b1;
        wake_softinit_i = 1'b1;
        wake_sysmgmt_i  = 1'b1;
        step();
        wake_nonmask_i  = 1'b0;
        wake_softinit_i = 1'b0;
        wake_sysmgmt_i  = 1'b0;
        chk("R8 source softinit", 32'(wake_src_o), 32'd2);
        chk("R8 softinit pulse", 32'(wake_o), 32'd1);

        // R8: non-maskable alone
        step();
        shut_to_halt();
        wake_nonmask_i = 1'b1;
        step();
        wake_nonmask_i = 1'b0;
        chk("R8 source nonmask", 32'(wake_src_o), 32'd1);
        chk("R8 nonmask exit", 32'(halted_o), 32'd0);

        step();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule